// File: doc/BRIEF.md
# Postfix Stack Evaluator

This block runs arithmetic written in postfix order on a small operand stack. It accepts a stream of two-field instructions: a 2-bit opcode and a 6-bit memory address. Only the push and pop operations use the address. A push copies a word from the block's data memory onto the stack. A pop removes the top entry and stores it to a memory word. The add and multiply operations have no operand address. Each one takes the two top stack entries and leaves a single result in their place.

The data memory holds the named variables of an expression. A host fills it through a separate load port before a program runs. Each stored result also appears on a registered store port, so the host can see the outcome without reading memory back. Each instruction is accepted on a valid/ready handshake and finishes before the next one is accepted. Two sticky-per-instruction flags report stack misuse: one for underflow and one for overflow.

Top module: `postfix_stack_unit`

## Requirements
- R1: After reset, `in_ready` is 1, `depth` is 0 and both `udf_flag` and `ovf_flag` are 0.
- R2: An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is then low for exactly one cycle, and the instruction's effects appear on the edge that ends that busy cycle.
- R3: Opcode 2'b00 (push) places the data-memory word at `in_addr` on top of the stack, and `depth` rises by one.
- R4: Opcode 2'b01 (pop) writes the top entry to data memory at `in_addr` and lowers `depth` by one. For that one cycle it also pulses `st_valid`, with `st_addr`/`st_data` giving the address and the value.
- R5: Opcode 2'b10 (add) replaces the two top entries with their sum modulo 2^16, and `depth` falls by one.
- R6: Opcode 2'b11 (multiply) replaces the two top entries with the low 16 bits of their product, and `depth` falls by one.
- R7: An add or multiply with fewer than two entries, or a pop with an empty stack, sets `udf_flag`. The stack is left unchanged and nothing is stored.
- R8: A push with `depth` equal to 8 sets `ovf_flag` and has no other effect. `depth` never exceeds 8.
- R9: Add and multiply give the same result whatever `in_addr` holds, and they never store.
- R10: `ld_we` writes `ld_data` into data memory at `ld_addr` only in a cycle where `in_ready` is high. A load request in a busy cycle is dropped.
- R11: The program push A, push B, add, push C, push D, add, multiply, pop X stores (A+B)*(C+D) into X.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction |
| in_op | input | 2 | Opcode: 00 push, 01 pop, 10 add, 11 multiply |
| in_addr | input | 6 | Memory word address (used by push and pop) |
| ld_we | input | 1 | Host load strobe |
| ld_addr | input | 6 | Host load address |
| ld_data | input | 16 | Host load value |
| depth | output | 4 | Number of stack entries |
| top_data | output | 16 | Top entry (0 when empty) |
| udf_flag | output | 1 | Last instruction underflowed |
| ovf_flag | output | 1 | Last instruction overflowed |
| st_valid | output | 1 | Pop result stored this cycle |
| st_addr | output | 6 | Address of the stored word |
| st_data | output | 16 | Value of the stored word |

## Verification
The bench builds the block with its defaults: 16-bit words, an 8-entry stack and 64 memory words. At these values a plain run of pushes reaches the full stack quickly, so overflow at exactly eight entries is tested directly. The 16-bit width lets small operands exercise wrap-around on add and truncation on multiply (300*300). A behavioural queue model follows every instruction, including underflow attempts at depths 0 and 1 and a load that is issued during a busy cycle.

// File: rtl/spk_pkg.sv
package spk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_MUL  = 2'b11
  } spk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } spk_state_e;
endpackage

// File: rtl/spk_dmem.sv
module spk_dmem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/spk_stack.sv
module spk_stack #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       merge,
  input  logic [DATA_W-1:0]          wdata,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic [DATA_W-1:0]          top,
  output logic [DATA_W-1:0]          nxt
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

  logic [DATA_W-1:0] arr [DEPTH];
  logic [CNT_W-1:0]  cm1, cm2;
  logic [IDX_W-1:0]  i_top, i_nxt, i_new;

  assign cm1   = cnt - ONE;
  assign cm2   = cnt - TWO;
  assign i_top = cm1[IDX_W-1:0];
  assign i_nxt = cm2[IDX_W-1:0];
  assign i_new = cnt[IDX_W-1:0];

  assign top = (cnt >= ONE) ? arr[i_top] : '0;
  assign nxt = (cnt >= TWO) ? arr[i_nxt] : '0;

  always_ff @(posedge clk) begin
    if (push && cnt < FULL)   arr[i_new] <= wdata;
    else if (merge && cnt >= TWO) arr[i_nxt] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (push && cnt < FULL) cnt <= cnt + ONE;
    else if ((pop && cnt >= ONE) || (merge && cnt >= TWO)) cnt <= cm1;
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  a_r3_push_grows: assert property (@(posedge clk) disable iff (rst)
    (push && cnt < FULL) |=> cnt == $past(cnt) + ONE);
  a_r5_merge_shrinks: assert property (@(posedge clk) disable iff (rst)
    (merge && cnt >= TWO) |=> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/spk_ctrl.sv
module spk_ctrl
  import spk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [1:0]                 in_op,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic [$clog2(DEPTH+1)-1:0] cnt,
  input  logic [DATA_W-1:0]          top,
  input  logic [DATA_W-1:0]          nxt,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic                       stk_push,
  output logic                       stk_pop,
  output logic                       stk_merge,
  output logic [DATA_W-1:0]          stk_wdata,
  output logic                       mem_store,
  output logic [ADDR_W-1:0]          mem_saddr,
  output logic                       udf_flag,
  output logic                       ovf_flag,
  output logic                       st_valid,
  output logic [ADDR_W-1:0]          st_addr,
  output logic [DATA_W-1:0]          st_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

  spk_state_e        state;
  spk_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              exec, ok, udf_c, ovf_c;
  logic [2*DATA_W-1:0] prod;

  assign in_ready = (state == ST_IDLE);
  assign exec     = (state == ST_EXEC);
  assign prod     = {{DATA_W{1'b0}}, nxt} * {{DATA_W{1'b0}}, top};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_q   <= OP_PUSH;
      addr_q <= '0;
    end else if (exec) begin
      state <= ST_IDLE;
    end else if (in_valid) begin
      state  <= ST_EXEC;
      op_q   <= spk_op_e'(in_op);
      addr_q <= in_addr;
    end
  end

  always_comb begin
    unique case (op_q)
      OP_PUSH: ok = (cnt < FULL);
      OP_POP:  ok = (cnt >= ONE);
      default: ok = (cnt >= TWO);
    endcase
    udf_c     = exec && !ok && (op_q != OP_PUSH);
    ovf_c     = exec && !ok && (op_q == OP_PUSH);
    stk_push  = exec && ok && (op_q == OP_PUSH);
    stk_pop   = exec && ok && (op_q == OP_POP);
    stk_merge = exec && ok && (op_q == OP_ADD || op_q == OP_MUL);
    mem_store = stk_pop;
    mem_saddr = addr_q;
    unique case (op_q)
      OP_ADD:  stk_wdata = nxt + top;
      OP_MUL:  stk_wdata = prod[DATA_W-1:0];
      default: stk_wdata = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      udf_flag <= 1'b0;
      ovf_flag <= 1'b0;
      st_valid <= 1'b0;
      st_addr  <= '0;
      st_data  <= '0;
    end else begin
      st_valid <= mem_store;
      if (exec) begin
        udf_flag <= udf_c;
        ovf_flag <= ovf_c;
      end
      if (mem_store) begin
        st_addr <= addr_q;
        st_data <= top;
      end
    end
  end

  a_r2_single_busy: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready);
  a_r7_udf_keeps_depth: assert property (@(posedge clk) disable iff (rst)
    udf_c |=> (udf_flag && !st_valid && cnt == $past(cnt)));
  a_r4_store_pulse: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> !st_valid);
  a_r8_ovf_at_full: assert property (@(posedge clk) disable iff (rst)
    ovf_c |=> (ovf_flag && cnt == FULL));
endmodule

// File: rtl/postfix_stack_unit.sv
module postfix_stack_unit #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [1:0]                 in_op,
  input  logic [ADDR_W-1:0]          in_addr,
  input  logic                       ld_we,
  input  logic [ADDR_W-1:0]          ld_addr,
  input  logic [DATA_W-1:0]          ld_data,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic [DATA_W-1:0]          top_data,
  output logic                       udf_flag,
  output logic                       ovf_flag,
  output logic                       st_valid,
  output logic [ADDR_W-1:0]          st_addr,
  output logic [DATA_W-1:0]          st_data
);
  logic              stk_push, stk_pop, stk_merge, mem_store;
  logic [DATA_W-1:0] stk_wdata, nxt, mem_rdata, mem_wdata;
  logic [ADDR_W-1:0] mem_saddr, mem_waddr;
  logic              mem_we;

  assign mem_we    = mem_store || (ld_we && in_ready);
  assign mem_waddr = mem_store ? mem_saddr : ld_addr;
  assign mem_wdata = mem_store ? top_data  : ld_data;

  spk_dmem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(in_addr), .rdata(mem_rdata)
  );

  spk_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push(stk_push), .pop(stk_pop), .merge(stk_merge),
    .wdata(stk_wdata), .cnt(depth), .top(top_data), .nxt(nxt)
  );

  spk_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .cnt(depth), .top(top_data), .nxt(nxt),
    .mem_rdata(mem_rdata), .stk_push(stk_push), .stk_pop(stk_pop),
    .stk_merge(stk_merge), .stk_wdata(stk_wdata), .mem_store(mem_store),
    .mem_saddr(mem_saddr), .udf_flag(udf_flag), .ovf_flag(ovf_flag),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
  );

  a_r10_load_idle_only: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !in_ready) |-> mem_store);
endmodule

// File: tb/sim_postfix_stack_unit.sv
module sim_postfix_stack_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = '0;
  logic [5:0] in_addr = '0;
  logic ld_we = 1'b0;
  logic [5:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [3:0] depth;
  logic [15:0] top_data, st_data;
  logic udf_flag, ovf_flag, st_valid;
  logic [5:0] st_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          m_stk[$];
  logic [15:0] m_mem [64];

  always #10 clk = ~clk;

  postfix_stack_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .depth(depth), .top_data(top_data),
    .udf_flag(udf_flag), .ovf_flag(ovf_flag), .st_valid(st_valid),
    .st_addr(st_addr), .st_data(st_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
    m_mem[a] = d;
  endtask

  task automatic instr(input logic [1:0] op, input logic [5:0] a, input string req);
    bit e_udf, e_ovf, e_st;
    int x, y;
    logic [15:0] e_sd;
    @(negedge clk);
    chk({req, " R2 ready idle"}, in_ready, 1);
    in_valid = 1'b1; in_op = op; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R2 busy"}, in_ready, 0);
    @(negedge clk);
    e_udf = 0; e_ovf = 0; e_st = 0; e_sd = '0;
    case (op)
      2'b00: if (m_stk.size() < 8) m_stk.push_back(int'(m_mem[a])); else e_ovf = 1;
      2'b01: if (m_stk.size() >= 1) begin
               e_sd = 16'(m_stk.pop_back()); m_mem[a] = e_sd; e_st = 1;
             end else e_udf = 1;
      default: if (m_stk.size() >= 2) begin
               y = m_stk.pop_back(); x = m_stk.pop_back();
               m_stk.push_back(op == 2'b10 ? int'(16'(x + y)) : int'(16'(x * y)));
             end else e_udf = 1;
    endcase
    chk({req, " ready after"}, in_ready, 1);
    chk({req, " depth"}, depth, m_stk.size());
    chk({req, " top"}, top_data, m_stk.size() > 0 ? m_stk[m_stk.size()-1] : 0);
    chk({req, " R7 udf"}, udf_flag, e_udf);
    chk({req, " R8 ovf"}, ovf_flag, e_ovf);
    chk({req, " R4 st_valid"}, st_valid, e_st);
    if (e_st) begin
      chk({req, " R4 st_addr"}, st_addr, a);
      chk({req, " R4 st_data"}, st_data, e_sd);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready", in_ready, 1);
    chk("R1 depth", depth, 0);
    chk("R1 udf", udf_flag, 0);
    chk("R1 ovf", ovf_flag, 0);

    // R10 / R11: load variables and run the postfix example
    load(0, 3); load(1, 4); load(2, 5); load(3, 6); load(10, 0);
    instr(2'b00, 0, "R11 push A");
    instr(2'b00, 1, "R11 push B");
    instr(2'b10, 0, "R11 add");
    instr(2'b00, 2, "R11 push C");
    instr(2'b00, 3, "R11 push D");
    instr(2'b10, 0, "R11 add");
    instr(2'b11, 0, "R11 mul");
    instr(2'b01, 10, "R11 pop X");
    chk("R11 result", m_mem[10], 77);
    instr(2'b00, 10, "R4 readback X");
    instr(2'b01, 11, "R4 pop");

    // R7: underflow cases
    instr(2'b10, 0, "R7 add empty");
    instr(2'b01, 5, "R7 pop empty");
    instr(2'b00, 0, "R3 push");
    instr(2'b11, 0, "R7 mul depth1");
    instr(2'b10, 0, "R7 add depth1");
    instr(2'b01, 5, "R4 drain");

    // R5 wrap, R6 truncation, R9 address ignored
    load(20, 16'hFFFF); load(21, 2); load(22, 300);
    instr(2'b00, 20, "R5 push");
    instr(2'b00, 21, "R5 push");
    instr(2'b10, 63, "R5 R9 add wraps");
    instr(2'b00, 22, "R6 push");
    instr(2'b00, 22, "R6 push");
    instr(2'b11, 37, "R6 R9 mul truncates");
    instr(2'b01, 40, "R6 store");
    instr(2'b01, 41, "R5 store");

    // R8: fill and overflow
    for (int i = 0; i < 8; i++) instr(2'b00, 6'(i), "R8 fill");
    instr(2'b00, 22, "R8 push full");
    for (int i = 0; i < 8; i++) instr(2'b01, 6'(48 + i), "R8 drain");

    // R10: load issued while busy is dropped
    load(30, 16'h0000);
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'b10; in_addr = 0;
    @(negedge clk);
    in_valid = 1'b0;
    ld_we = 1'b1; ld_addr = 30; ld_data = 16'h1234;
    @(negedge clk);
    ld_we = 1'b0;
    chk("R10 underflow during busy load", udf_flag, 1);
    instr(2'b00, 30, "R10 busy load dropped");
    chk("R10 top", top_data, 0);
    instr(2'b01, 31, "R10 drain");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule